// File: doc/BRIEF.md
# Host Port Acknowledge Generator

This block drives the single handshake line that a slave bus port gives back to an external host during each strobed access. The host raises a read strobe, a write strobe or an address-cycle strobe. The block compares that access with status flags from the rest of the port: read data valid, write buffer full, and port busy writing. It then tells the host either to finish the access or to keep holding its strobe.

Two handshake styles are supported. In the acknowledge style the line stays inactive until the access is allowed to finish, and only then becomes active. In the ready style the line rests active and goes inactive only to insert wait states. Two strap pins are sampled while reset is held. They fix the electrical polarity of the line, which software can read but not change. They also set the starting style, which software can later rewrite through a two-bit mode field.

Host strobes arrive asynchronously, so they pass through a synchronizer. All decision logic works active-high, and the polarity is applied in the final registered stage.

Top module: `host_ack_gen`

## Requirements
- R1: While `rst_n` is low, `cfg_pol` takes the value of `strap_pol` and keeps it after reset. A value of 1 means the acknowledge line is active-high; 0 means active-low.
- R2: Reset loads `cfg_mode[0]` with the XNOR of `strap_pol` and `strap_sel` and loads `cfg_mode[1]` with 0. Straps 00 and 11 therefore give ready style (`cfg_mode[0]`=1), and straps 01 and 10 give acknowledge style (`cfg_mode[0]`=0).
- R3: A cycle with `cfg_we` high loads `cfg_wdata` into `cfg_mode`. Only `cfg_mode[0]` selects the style; `cfg_mode[1]` is stored and read back but does not change `ack_out`.
- R4: In acknowledge style, a read strobe makes the line active only when `rbuf_valid` is 1 and `wr_busy` is 0. The line is inactive when no strobe is present.
- R5: In acknowledge style, a write strobe makes the line active only when `wbuf_full` is 0 and `wr_busy` is 0.
- R6: In ready style, the line is active when no strobe is present and during any strobe whose access can complete. It is inactive during a read or write strobe that cannot yet complete, under the same conditions as R4 and R5.
- R7: An address-cycle strobe makes the line active in both styles, whatever the status flags are.
- R8: `ack_out` equals the active-high decision when `cfg_pol`=1 and its inverse when `cfg_pol`=0. Mode writes leave `cfg_pol` unchanged. During reset `ack_out` sits at the inactive level of the strapped polarity.
- R9: A change on a host strobe reaches `ack_out` on the third rising edge (two synchronizer stages plus the output register). A change on a status flag reaches `ack_out` on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while low |
| strap_pol | input | 1 | Polarity strap (1 = active-high) |
| strap_sel | input | 1 | Second strap used to choose the starting style |
| hst_rd | input | 1 | Host read strobe, asynchronous, active-high |
| hst_wr | input | 1 | Host write strobe, asynchronous, active-high |
| hst_addr_cyc | input | 1 | Host address-cycle strobe, asynchronous, active-high |
| rbuf_valid | input | 1 | Read buffer holds valid data |
| wbuf_full | input | 1 | Write buffer is full |
| wr_busy | input | 1 | Port is busy performing a write |
| cfg_we | input | 1 | Mode field write enable |
| cfg_wdata | input | 2 | Mode field write data |
| cfg_mode | output | 2 | Mode field readback; bit 0 selects ready style |
| cfg_pol | output | 1 | Read-only polarity bit |
| ack_out | output | 1 | Acknowledge / ready line to the host |

## Verification
The bench uses the default of two synchronizer stages. With that setting the strobe-to-line delay is exactly three edges, and the one-edge path from the status flags can be measured against it in the same scenario. All four strap combinations are reset in turn, so both polarities meet both starting styles. Runtime mode writes, including one that sets only the upper bit, then cover the style changes that the straps alone cannot reach.

// File: rtl/hak_pkg.sv
package hak_pkg;
    localparam int MODE_W    = 2;
    localparam int STYLE_BIT = 0;
    localparam int N_STRB    = 3;

    typedef struct packed {
        logic              pol;
        logic [MODE_W-1:0] mode;
    } cfg_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ac;
    } strb_t;
endpackage

// File: rtl/hak_sync.sv
module hak_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[LAST];
endmodule

// File: rtl/hak_cfg.sv
module hak_cfg
    import hak_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_pol,
    input  logic              strap_sel,
    input  logic              we,
    input  logic [MODE_W-1:0] wdata,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d.pol             = strap_pol;
            cfg_d.mode            = '0;
            cfg_d.mode[STYLE_BIT] = ~(strap_pol ^ strap_sel);
        end else if (we) begin
            cfg_d.mode = wdata;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R3
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q.mode));
endmodule

// File: rtl/hak_resp.sv
module hak_resp
    import hak_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  strb_t strb,
    input  logic  rbuf_valid,
    input  logic  wbuf_full,
    input  logic  wr_busy,
    input  logic  ready_style,
    input  logic  pol_lvl,
    output logic  ack_out
);
    typedef struct packed {
        logic ack;
    } resp_t;

    resp_t st_d, st_q;
    logic  rd_ok, wr_ok, pass, act;

    always_comb begin
        rd_ok = rbuf_valid & ~wr_busy;
        wr_ok = ~wbuf_full & ~wr_busy;
        pass  = (~strb.rd | rd_ok) & (~strb.wr | wr_ok);
        if (ready_style) act = strb.ac | pass;
        else             act = strb.ac | ((strb.rd | strb.wr) & pass);
        st_d.ack = rst_n ? (act ^ ~pol_lvl) : ~pol_lvl;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ack_out = st_q.ack;
endmodule

// File: rtl/host_ack_gen.sv
module host_ack_gen
    import hak_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_pol,
    input  logic       strap_sel,
    input  logic       hst_rd,
    input  logic       hst_wr,
    input  logic       hst_addr_cyc,
    input  logic       rbuf_valid,
    input  logic       wbuf_full,
    input  logic       wr_busy,
    input  logic       cfg_we,
    input  logic [1:0] cfg_wdata,
    output logic [1:0] cfg_mode,
    output logic       cfg_pol,
    output logic       ack_out
);
    strb_t raw_s, sync_s;
    cfg_t  cfg;
    logic  pol_lvl;

    assign raw_s = '{rd: hst_rd, wr: hst_wr, ac: hst_addr_cyc};

    hak_sync #(.W(N_STRB), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_s),
        .dout (sync_s)
    );

    hak_cfg i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_pol(strap_pol),
        .strap_sel(strap_sel),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .cfg      (cfg)
    );

    assign pol_lvl = rst_n ? cfg.pol : strap_pol;

    hak_resp i_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .strb       (sync_s),
        .rbuf_valid (rbuf_valid),
        .wbuf_full  (wbuf_full),
        .wr_busy    (wr_busy),
        .ready_style(cfg.mode[STYLE_BIT]),
        .pol_lvl    (pol_lvl),
        .ack_out    (ack_out)
    );

    assign cfg_mode = cfg.mode;
    assign cfg_pol  = cfg.pol;

    // R4
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.mode[STYLE_BIT] && !sync_s.rd && !sync_s.wr && !sync_s.ac)
        |=> ack_out == ~cfg_pol);

    // R4
    rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_s.rd && !sync_s.ac && !rbuf_valid) |=> ack_out == ~cfg_pol);

    // R6
    ready_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode[STYLE_BIT] && sync_s.wr && wbuf_full && !sync_s.ac)
        |=> ack_out == ~cfg_pol);

    // R7
    addr_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_s.ac |=> ack_out == cfg_pol);

    // R8
    pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> $stable(cfg_pol));
endmodule

// File: tb/test_host_ack_gen.sv
module test_host_ack_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_pol = 1'b1, strap_sel = 1'b0;
    logic       hst_rd = 1'b0, hst_wr = 1'b0, hst_addr_cyc = 1'b0;
    logic       rbuf_valid = 1'b0, wbuf_full = 1'b0, wr_busy = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_wdata = 2'b00;
    logic [1:0] cfg_mode;
    logic       cfg_pol;
    logic       ack_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    host_ack_gen i_host_ack_gen (
        .clk(clk), .rst_n(rst_n), .strap_pol(strap_pol), .strap_sel(strap_sel),
        .hst_rd(hst_rd), .hst_wr(hst_wr), .hst_addr_cyc(hst_addr_cyc),
        .rbuf_valid(rbuf_valid), .wbuf_full(wbuf_full), .wr_busy(wr_busy),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_mode(cfg_mode),
        .cfg_pol(cfg_pol), .ack_out(ack_out)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // level the line shows for an active (1) or inactive (0) decision
    function automatic logic lvl(input logic pol, input logic active);
        return pol ? active : ~active;
    endfunction

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic rd, input logic wr, input logic ac,
                         input logic rv, input logic wf, input logic bz);
        @(negedge clk);
        hst_rd = rd; hst_wr = wr; hst_addr_cyc = ac;
        rbuf_valid = rv; wbuf_full = wf; wr_busy = bz;
        settle();
    endtask

    task automatic do_reset(input logic p, input logic s);
        @(negedge clk);
        rst_n = 1'b0; strap_pol = p; strap_sel = s;
        hst_rd = 0; hst_wr = 0; hst_addr_cyc = 0;
        rbuf_valid = 0; wbuf_full = 0; wr_busy = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset level", ack_out, lvl(p, 1'b0));
        rst_n = 1'b1;
        strap_pol = ~p; strap_sel = ~s;
        settle();
    endtask

    task automatic write_mode(input logic [1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        settle();
    endtask

    task automatic t_reset_straps();
        for (int k = 0; k < 4; k++) begin
            logic p, s;
            p = k[1]; s = k[0];
            do_reset(p, s);
            chk("R1 pol strap", cfg_pol, p);
            chk("R2 mode strap", cfg_mode, {1'b0, ~(p ^ s)});
            chk("R2 idle level", ack_out, lvl(p, ~(p ^ s)));
        end
    endtask

    task automatic t_ack_read();
        do_reset(1'b1, 1'b0);
        drive(1, 0, 0, 0, 0, 0); chk("R4 rd no data", ack_out, 1'b0);
        drive(1, 0, 0, 1, 0, 1); chk("R4 rd busy", ack_out, 1'b0);
        drive(1, 0, 0, 1, 0, 0); chk("R4 rd ok", ack_out, 1'b1);
        drive(0, 0, 0, 1, 0, 0); chk("R4 strobe removed", ack_out, 1'b0);
    endtask

    task automatic t_ack_write();
        do_reset(1'b0, 1'b1);
        chk("R1 active low", cfg_pol, 1'b0);
        drive(0, 1, 0, 0, 1, 0); chk("R5 wr full", ack_out, 1'b1);
        drive(0, 1, 0, 0, 0, 1); chk("R5 wr busy", ack_out, 1'b1);
        drive(0, 1, 0, 0, 0, 0); chk("R5 wr ok", ack_out, 1'b0);
    endtask

    task automatic t_ready();
        do_reset(1'b1, 1'b1);
        chk("R6 idle ready", ack_out, 1'b1);
        drive(0, 1, 0, 0, 1, 0); chk("R6 wr wait", ack_out, 1'b0);
        drive(0, 1, 0, 0, 0, 0); chk("R6 wr go", ack_out, 1'b1);
        drive(1, 0, 0, 0, 0, 0); chk("R6 rd wait", ack_out, 1'b0);
        drive(1, 0, 0, 1, 0, 1); chk("R6 rd busy wait", ack_out, 1'b0);
        drive(1, 0, 0, 1, 0, 0); chk("R6 rd go", ack_out, 1'b1);
    endtask

    task automatic t_addr_cycle();
        do_reset(1'b1, 1'b0);
        drive(0, 0, 1, 0, 1, 1); chk("R7 addr ack style", ack_out, 1'b1);
        do_reset(1'b1, 1'b1);
        drive(0, 0, 1, 0, 1, 1); chk("R7 addr ready style", ack_out, 1'b1);
        drive(0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_polarity();
        do_reset(1'b0, 1'b0);
        chk("R8 ready idle low", ack_out, 1'b0);
        drive(1, 0, 0, 0, 0, 0); chk("R8 wait high", ack_out, 1'b1);
        drive(0, 0, 0, 0, 0, 0);
        write_mode(2'b00);
        chk("R3 mode write", cfg_mode, 2'b00);
        chk("R8 pol unchanged", cfg_pol, 1'b0);
        chk("R8 ack idle high", ack_out, 1'b1);
    endtask

    task automatic t_mode_upper();
        do_reset(1'b1, 1'b1);
        write_mode(2'b10);
        chk("R3 upper stored", cfg_mode, 2'b10);
        chk("R3 upper no effect idle", ack_out, 1'b0);
        drive(1, 0, 0, 1, 0, 0); chk("R3 upper no effect rd", ack_out, 1'b1);
        drive(0, 0, 0, 0, 0, 0);
        write_mode(2'b11);
        chk("R3 ready again", ack_out, 1'b1);
    endtask

    task automatic t_latency();
        do_reset(1'b1, 1'b0);
        @(negedge clk);
        rbuf_valid = 1'b1; hst_rd = 1'b1;
        @(posedge clk); @(negedge clk); chk("R9 edge1", ack_out, 1'b0);
        @(posedge clk); @(negedge clk); chk("R9 edge2", ack_out, 1'b0);
        @(posedge clk); @(negedge clk); chk("R9 edge3", ack_out, 1'b1);
        rbuf_valid = 1'b0;
        @(posedge clk); @(negedge clk); chk("R9 status 1 edge", ack_out, 1'b0);
        rbuf_valid = 1'b1;
        @(posedge clk); @(negedge clk); chk("R9 status back", ack_out, 1'b1);
        drive(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        t_reset_straps();
        t_ack_read();
        t_ack_write();
        t_ready();
        t_addr_cycle();
        t_polarity();
        t_mode_upper();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule